// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block is the digital control of a 12-bit sampling converter as seen from the device side. An active-low convert-start line is watched for edges. A falling edge places the track-and-hold stage in hold and begins a conversion, and a busy status output is raised. The conversion time is modelled by counting system clock cycles. When the count expires, busy drops, the hold command is released so the input returns to tracking, and a result word taken from a stub input port is written into the output register.

The level of convert-start at the moment a conversion finishes picks the operating mode. If the line is high, the block stays awake and is ready for the next falling edge. If the line is still low, the block drops into power-down. A rising edge then starts a fixed wake-up delay. At the end of that delay a conversion begins at once when the line has already returned low. Otherwise the block waits, awake, for the next falling edge. A falling edge that arrives during a conversion does not start a new one and sets a sticky overrun flag. All timing is given by parameters in system clock cycles. The defaults are 60 cycles of wake-up and 80 cycles of conversion, which suit a 10 MHz reference clock.

Top module: `adc_conv_seq`

## Requirements
- R1: While awake and idle, a falling edge of `startN` (active low) raises `busy` and `hold` on the first clock edge that samples `startN` low.
- R2: In the high-rate mode, `busy` stays high for exactly `CONV_CYCLES` clock cycles.
- R3: `dataOut` takes the value of `resultIn` on the clock edge at which `busy` falls, and it keeps that value at every other time.
- R4: When a conversion ends, `asleep` goes to 1 if `startN` is low and stays 0 if `startN` is high.
- R5: While asleep, a rising edge of `startN` clears `asleep` and starts a wake-up of exactly `WAKE_CYCLES` cycles. If `startN` is low when the wake-up ends, `busy` rises on the next cycle.
- R6: If `startN` is still high when the wake-up ends, the block stays awake with `busy` low, and the conversion starts only at the next falling edge.
- R7: `hold` falls on the same edge as `busy`, which returns the track-and-hold stage to tracking.
- R8: A falling edge of `startN` while `busy` is high neither shortens nor extends the conversion and starts no second conversion. It sets `overrun` to 1, and only reset clears it.
- R9: After reset, `busy`, `hold`, `asleep` and `overrun` are 0, `dataOut` is 0, and the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startN | input | 1 | Convert-start line, active low, already synchronous to clk |
| resultIn | input | RES_BITS | Conversion result word from the stub bit-trial logic |
| busy | output | 1 | High while a conversion is in progress |
| hold | output | 1 | Hold command to the track-and-hold stage |
| asleep | output | 1 | High while the block is powered down |
| dataOut | output | RES_BITS | Output register holding the latest result |
| overrun | output | 1 | Sticky flag: a start edge arrived during a conversion |

## Verification
The assertions assume that `startN` is already synchronous to `clk`, so each of its edges is seen exactly once. They also assume `resultIn` is stable around the edge at which `busy` falls. Every pulse is at least one clock cycle wide. The bench drives `startN` and `resultIn` only on falling clock edges and holds every level for one cycle or longer. The one falling edge during a conversion is placed deliberately, to exercise the overrun path.

// File: rtl/adc_conv_seq_pkg.sv
package adc_conv_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic loadResult;
    logic flagOverrun;
  } seq_strobe_t;

endpackage

// File: rtl/adc_conv_seq_ctrl.sv
module adc_conv_seq_ctrl
  import adc_conv_seq_pkg::*;
#(
  parameter int WAKE_CYCLES = 60,
  parameter int CONV_CYCLES = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startN,
  output seq_strobe_t strobe,
  output logic        busy,
  output logic        hold,
  output logic        asleep
);

  localparam int MAX_CYCLES = (WAKE_CYCLES > CONV_CYCLES) ? WAKE_CYCLES : CONV_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);

  seq_state_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             startQ;
  logic             fallEdge, riseEdge;

  // One-cycle history of the start line for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) startQ <= 1'b1;
    else       startQ <= startN;
  end

  assign fallEdge = startQ & ~startN;
  assign riseEdge = ~startQ & startN;

  always_comb begin
    stateNext          = state;
    cntNext            = '0;
    strobe.loadResult  = 1'b0;
    strobe.flagOverrun = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fallEdge) stateNext = ST_CONV;
      end
      ST_CONV: begin
        strobe.flagOverrun = fallEdge;
        if (cnt == CONV_LAST) begin
          strobe.loadResult = 1'b1;
          stateNext         = startN ? ST_IDLE : ST_SLEEP;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_SLEEP: begin
        if (riseEdge) stateNext = ST_WAKE;
      end
      ST_WAKE: begin
        if (cnt == WAKE_LAST) stateNext = startN ? ST_IDLE : ST_CONV;
        else                  cntNext   = cnt + 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign busy   = (state == ST_CONV);
  assign hold   = (state == ST_CONV);
  assign asleep = (state == ST_SLEEP);

  // R1: a start edge while awake and idle begins a conversion
  a_r1_start_edge: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && fallEdge) |=> (busy && hold));

  // R4: the sleep decision follows the start line level at conversion end
  a_r4_mode_choice: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (asleep == !$past(startN)));

  // R5: power-down persists until a rising edge of the start line
  a_r5_stay_asleep: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && !$rose(startN)) |=> asleep);

  // R5: a rising edge while asleep wakes the block without starting a conversion
  a_r5_wake_begin: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && $rose(startN)) |=> (!asleep && !busy));

  // R7: tracking resumes with the end of busy
  a_r7_track_on_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !hold);

endmodule

// File: rtl/adc_conv_seq_datapath.sv
module adc_conv_seq_datapath
  import adc_conv_seq_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strobe,
  input  logic [RES_BITS-1:0] resultIn,
  output logic [RES_BITS-1:0] dataOut,
  output logic                overrun
);

  always_ff @(posedge clk) begin
    if (!rstN)                  dataOut <= '0;
    else if (strobe.loadResult) dataOut <= resultIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   overrun <= 1'b0;
    else if (strobe.flagOverrun) overrun <= 1'b1;
  end

  // R8: the overrun flag is sticky until reset
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_seq_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int WAKE_CYCLES = 60,
  parameter int CONV_CYCLES = 80
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startN,
  input  logic [RES_BITS-1:0] resultIn,
  output logic                busy,
  output logic                hold,
  output logic                asleep,
  output logic [RES_BITS-1:0] dataOut,
  output logic                overrun
);

  seq_strobe_t strobe;

  adc_conv_seq_ctrl #(
    .WAKE_CYCLES(WAKE_CYCLES),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .startN(startN),
    .strobe(strobe),
    .busy  (busy),
    .hold  (hold),
    .asleep(asleep)
  );

  adc_conv_seq_datapath #(
    .RES_BITS(RES_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .resultIn(resultIn),
    .dataOut (dataOut),
    .overrun (overrun)
  );

  // R3: the output register changes only on the edge where busy falls
  a_r3_load_once: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $fell(busy));

endmodule

// File: tb/adc_conv_seq_test.sv
module adc_conv_seq_test;

  localparam int RES_BITS = 12;
  localparam int WAKE     = 60;
  localparam int CONV     = 80;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                startN = 1'b1;
  logic [RES_BITS-1:0] resultIn = '0;
  logic                busy, hold, asleep, overrun;
  logic [RES_BITS-1:0] dataOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  adc_conv_seq #(
    .RES_BITS(RES_BITS),
    .WAKE_CYCLES(WAKE),
    .CONV_CYCLES(CONV)
  ) uut (
    .clk(clk), .rstN(rstN), .startN(startN), .resultIn(resultIn),
    .busy(busy), .hold(hold), .asleep(asleep), .dataOut(dataOut), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Counts busy samples, the first one already seen; optional start pulse at count pulseAt
  task automatic countBusy(input int pulseAt, output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (pulseAt > 0 && n == pulseAt)     startN = 1'b0;
      if (pulseAt > 0 && n == pulseAt + 1) startN = 1'b1;
      if (n > 1000) break;
    end
  endtask

  // Counts idle samples until busy rises; drops startN after dropAt samples
  task automatic countIdle(input int dropAt, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (busy) break;
      n++;
      if (n == dropAt) startN = 1'b0;
      if (n > 1000) break;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    startN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 busy after reset", busy, 0);
    chk("R9 hold after reset", hold, 0);
    chk("R9 asleep after reset", asleep, 0);
    chk("R9 overrun after reset", overrun, 0);
    chk("R9 dataOut after reset", dataOut, 0);
  endtask

  task automatic testHighRate();
    int n;
    startN = 1'b0;
    resultIn = 12'hA5C;
    @(negedge clk);
    chk("R1 busy after start edge", busy, 1);
    chk("R1 hold after start edge", hold, 1);
    chk("R3 dataOut unchanged during conversion", dataOut, 0);
    startN = 1'b1;
    countBusy(0, n);
    chk("R2 busy length", n, CONV);
    chk("R3 result loaded", dataOut, 12'hA5C);
    chk("R7 hold released", hold, 0);
    chk("R4 awake after high-rate conversion", asleep, 0);
  endtask

  task automatic testSleepEntry();
    int n;
    startN = 1'b0;
    resultIn = 12'h3F1;
    @(negedge clk);
    chk("R1 busy in sleep-mode conversion", busy, 1);
    countBusy(0, n);
    chk("R2 busy length before sleep", n, CONV);
    chk("R4 asleep when start low at end", asleep, 1);
    chk("R3 result loaded before sleep", dataOut, 12'h3F1);
    resultIn = 12'h7FF;
    repeat (20) @(negedge clk);
    chk("R4 still asleep", asleep, 1);
    chk("R3 dataOut holds while asleep", dataOut, 12'h3F1);
    chk("R5 no conversion while asleep", busy, 0);
  endtask

  task automatic testWakeShort();
    int nIdle, nBusy;
    startN = 1'b1;
    resultIn = 12'h124;
    @(negedge clk);
    chk("R5 asleep cleared by rising edge", asleep, 0);
    chk("R5 no busy during wake", busy, 0);
    countIdle(9, nIdle);
    nIdle = nIdle + 1;
    chk("R5 wake length", nIdle, WAKE);
    countBusy(0, nBusy);
    chk("R5 conversion length after wake", nBusy, CONV);
    chk("R5 result after wake", dataOut, 12'h124);
    chk("R4 asleep again", asleep, 1);
  endtask

  task automatic testWakeLong();
    int n;
    startN = 1'b1;
    resultIn = 12'h800;
    repeat (WAKE + 40) @(negedge clk);
    chk("R6 no busy with start held high", busy, 0);
    chk("R6 awake after wake", asleep, 0);
    chk("R6 dataOut unchanged", dataOut, 12'h124);
    startN = 1'b0;
    @(negedge clk);
    chk("R6 busy on later falling edge", busy, 1);
    startN = 1'b1;
    countBusy(0, n);
    chk("R6 conversion length", n, CONV);
    chk("R6 result loaded", dataOut, 12'h800);
    chk("R4 awake with start high at end", asleep, 0);
  endtask

  task automatic testOverrun();
    int n;
    chk("R8 overrun clear before", overrun, 0);
    startN = 1'b0;
    resultIn = 12'h055;
    @(negedge clk);
    startN = 1'b1;
    countBusy(10, n);
    chk("R8 conversion length unchanged", n, CONV);
    chk("R8 overrun set", overrun, 1);
    chk("R8 result loaded", dataOut, 12'h055);
    resultIn = 12'h0AA;
    repeat (10) @(negedge clk);
    chk("R8 no second conversion", busy, 0);
    chk("R8 dataOut kept", dataOut, 12'h055);
    startN = 1'b0;
    @(negedge clk);
    startN = 1'b1;
    countBusy(0, n);
    chk("R8 overrun sticky", overrun, 1);
    chk("R3 next result", dataOut, 12'h0AA);
    doReset();
    chk("R8 overrun cleared by reset", overrun, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    testHighRate();
    repeat (3) @(negedge clk);
    testSleepEntry();
    testWakeShort();
    testWakeLong();
    repeat (3) @(negedge clk);
    testOverrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule